// File: doc/BRIEF.md
# Binary-Weight Dot-Product Accumulator

This block forms the dot products of a binarized convolution layer without any per-term multiplier. Each clock it can take `LANES` pairs. A pair is a signed fixed-point activation and a one-bit weight. A weight of 1 adds the activation to a running sum, and a weight of 0 subtracts it. The per-lane terms are reduced in an adder tree and then added into a wide accumulator. The accumulator is sized so that no permitted job length can overflow it.

Software or an upstream sequencer starts a job with a one-cycle start pulse. The pulse carries the job length in beats and a signed fixed-point scale factor. The scale factor is the mean that was removed from the real-valued coefficients when they were binarized. The block then accepts exactly that many valid beats. After the last beat it multiplies the sum once by the scale, rounds to nearest, saturates to the output width, and presents the result with a one-cycle strobe. The result stays on the output until the next job completes.

Top module: `bcv_acc_top`

## Requirements
- R1: Lane i takes activation bits `act_i[i*ACT_W +: ACT_W]` as two's complement and weight bit `wgt_i[i]`. Weight 1 adds the activation to the sum and weight 0 subtracts it.
- R2: All `LANES` lanes of an accepted beat enter the sum in the same beat.
- R3: A beat is accepted only while a job runs, `in_valid_i` is high, `start_i` is low and fewer than the job length beats have been taken. Any other beat leaves the sum and the result unchanged.
- R4: A `start_i` pulse clears the sum and captures `len_i` and `scale_i`. A pulse during a running job abandons that job, and only the new job produces a result.
- R5: The result equals the sum times `scale_i`, divided by 2^FRAC_W.
- R6: Rounding is to nearest, and exact halves go toward positive infinity.
- R7: A value outside the signed `OUT_W` range is clamped to the nearest limit.
- R8: `out_valid_o` is high for exactly one cycle. It rises on the third rising edge after the edge that accepted the last beat, or after the start edge when the length is zero. `busy_o` is low while `out_valid_o` is high.
- R9: A job of length zero yields a result of 0.
- R10: The sum does not wrap, even for the longest job (2^LEN_W-1 beats) with every term at its extreme value.
- R11: After reset `out_valid_o` and `busy_o` are low and `result_o` is 0. `result_o` changes only in the cycle where `out_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a job; clears the sum |
| len_i | input | LEN_W | Beats in the job, sampled at start |
| scale_i | input | SCALE_W | Signed scale, FRAC_W fractional bits, sampled at start |
| in_valid_i | input | 1 | Beat qualifier |
| act_i | input | LANES*ACT_W | Packed signed activations |
| wgt_i | input | LANES | Weight bits, one per lane |
| busy_o | output | 1 | Job in progress |
| out_valid_o | output | 1 | One-cycle result strobe |
| result_o | output | OUT_W | Scaled, rounded, saturated result |

## Verification
A sign error in a single lane, a lost tree level or an accumulator that is too narrow shows up in `result_o` at the end of the job that caused it. So the first random job with that weight pattern exposes it. Errors in the beat count or in the accept condition show in two ways. The strobe lands on the wrong edge relative to the last beat, and extra or missing terms change the value. Directed jobs with all weights set, all weights clear, exact halves, both saturation limits, a zero length and an abort all target the corners that random data rarely reaches.

// File: rtl/bcv_pkg.sv
package bcv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_MUL,
    ST_RND
  } bcv_state_e;
endpackage

// File: rtl/bcv_term_tree.sv
module bcv_term_tree #(
  parameter int LANES = 4,
  parameter int ACT_W = 8,
  localparam int DEPTH = (LANES > 1) ? $clog2(LANES) : 0,
  localparam int SUM_W = ACT_W + 1 + DEPTH
) (
  input  logic [LANES*ACT_W-1:0] act_i,
  input  logic [LANES-1:0]       wgt_i,
  output logic [SUM_W-1:0]       sum_o
);
  localparam int P2 = 1 << DEPTH;

  logic signed [SUM_W-1:0] node [2*P2-1];

  // leaves: sign-extended +/- term, padded lanes contribute zero
  for (genvar i = 0; i < P2; i++) begin : g_leaf
    if (i < LANES) begin : g_act
      logic signed [ACT_W-1:0] a;
      logic signed [SUM_W-1:0] a_ext;
      assign a     = act_i[i*ACT_W +: ACT_W];
      assign a_ext = SUM_W'(a);
      assign node[P2-1+i] = wgt_i[i] ? a_ext : -a_ext;
    end else begin : g_pad
      assign node[P2-1+i] = '0;
    end
  end

  for (genvar n = 0; n < P2 - 1; n++) begin : g_add
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  assign sum_o = node[0];
endmodule

// File: rtl/bcv_scale_unit.sv
module bcv_scale_unit #(
  parameter int ACC_W   = 27,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 8,
  parameter int OUT_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mul_en_i,
  input  logic               rnd_en_i,
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [OUT_W-1:0]   result_o
);
  localparam int PROD_W = ACC_W + SCALE_W;
  localparam int EXT_W  = PROD_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) << (FRAC_W - 1);
  localparam logic signed [EXT_W-1:0] SAT_HI =
    {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] SAT_LO =
    {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod_q;
  logic signed [EXT_W-1:0]  biased, shifted;
  logic signed [OUT_W-1:0]  sat_val, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else if (mul_en_i) prod_q <= $signed(acc_i) * $signed(scale_i);
  end

  always_comb begin
    biased  = EXT_W'(prod_q) + HALF;
    shifted = biased >>> FRAC_W;
    if (shifted > SAT_HI)      sat_val = SAT_HI[OUT_W-1:0];
    else if (shifted < SAT_LO) sat_val = SAT_LO[OUT_W-1:0];
    else                       sat_val = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else if (rnd_en_i) res_q <= sat_val;
  end

  assign result_o = res_q;
endmodule

// File: rtl/bcv_acc_top.sv
module bcv_acc_top
  import bcv_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int ACT_W   = 8,
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 8,
  parameter int OUT_W   = 24,
  parameter int LEN_W   = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [SCALE_W-1:0]     scale_i,
  input  logic                   in_valid_i,
  input  logic [LANES*ACT_W-1:0] act_i,
  input  logic [LANES-1:0]       wgt_i,
  output logic                   busy_o,
  output logic                   out_valid_o,
  output logic [OUT_W-1:0]       result_o
);
  localparam int DEPTH = (LANES > 1) ? $clog2(LANES) : 0;
  localparam int SUM_W = ACT_W + 1 + DEPTH;
  localparam int ACC_W = SUM_W + LEN_W;

  bcv_state_e st_q;
  logic [ACC_W-1:0]   acc_q;
  logic [LEN_W-1:0]   cnt_q, len_q;
  logic [SCALE_W-1:0] scale_q;
  logic [SUM_W-1:0]   tree_sum;
  logic               accept, last_done, out_vld_q, mul_en, rnd_en;

  bcv_term_tree #(.LANES(LANES), .ACT_W(ACT_W)) u_tree (
    .act_i (act_i),
    .wgt_i (wgt_i),
    .sum_o (tree_sum)
  );

  assign last_done = (cnt_q == len_q);
  assign accept    = (st_q == ST_RUN) && !start_i && in_valid_i && !last_done;
  assign mul_en    = (st_q == ST_MUL) && !start_i;
  assign rnd_en    = (st_q == ST_RND) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      acc_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      scale_q <= '0;
    end else if (start_i) begin
      st_q    <= ST_RUN;
      acc_q   <= '0;
      cnt_q   <= '0;
      len_q   <= len_i;
      scale_q <= scale_i;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (last_done) st_q <= ST_MUL;
          else if (accept) begin
            acc_q <= acc_q + {{(ACC_W-SUM_W){tree_sum[SUM_W-1]}}, tree_sum};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_MUL:  st_q <= ST_RND;
        ST_RND:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_vld_q <= 1'b0;
    else         out_vld_q <= rnd_en;
  end

  bcv_scale_unit #(
    .ACC_W(ACC_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)
  ) u_scale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mul_en_i (mul_en),
    .rnd_en_i (rnd_en),
    .acc_i    (acc_q),
    .scale_i  (scale_q),
    .result_o (result_o)
  );

  assign busy_o      = (st_q != ST_IDLE);
  assign out_valid_o = out_vld_q;
endmodule

// File: rtl/bcv_acc_chk.sv
module bcv_acc_chk #(
  parameter int ACC_W = 27,
  parameter int LEN_W = 16,
  parameter int OUT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             in_valid_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] result_o,
  input logic [ACC_W-1:0] acc_q,
  input logic [LEN_W-1:0] cnt_q,
  input logic [LEN_W-1:0] len_q
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !busy_o);
  // R3
  hold_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !start_i) |=> $stable(acc_q));
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= len_q));
  // R4
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (acc_q == '0 && cnt_q == '0 && busy_o));
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> out_valid_o);
endmodule

bind bcv_acc_top bcv_acc_chk #(.ACC_W(ACC_W), .LEN_W(LEN_W), .OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .in_valid_i  (in_valid_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .acc_q       (acc_q),
  .cnt_q       (cnt_q),
  .len_q       (len_q)
);

// File: tb/bcv_acc_top_tb.sv
module bcv_acc_top_tb;
  localparam int LANES = 4, ACT_W = 8, SCALE_W = 16, FRAC_W = 8, OUT_W = 24, LEN_W = 16;
  localparam longint OMAX = (longint'(1) << (OUT_W-1)) - 1;
  localparam longint OMIN = -(longint'(1) << (OUT_W-1));

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, in_valid_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [SCALE_W-1:0] scale_i = '0;
  logic [LANES*ACT_W-1:0] act_i = '0;
  logic [LANES-1:0] wgt_i = '0;
  logic busy_o, out_valid_o;
  logic [OUT_W-1:0] result_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  bcv_acc_top #(.LANES(LANES), .ACT_W(ACT_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W),
                .OUT_W(OUT_W), .LEN_W(LEN_W)) u_dut (.*);

  function automatic longint exp_res(longint acc, longint sc);
    longint p = acc * sc;
    longint r = (p + (longint'(1) << (FRAC_W-1))) >>> FRAC_W;
    if (r > OMAX) return OMAX;
    if (r < OMIN) return OMIN;
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 random, 1 weights all 1, 2 weights all 0, 3 extreme (-128, w=1), 4 lane0=fixv w=1
  task automatic run_job(int len, int sc, int mode, int fixv, bit gaps, bit junk, string tag);
    longint acc = 0;
    @(negedge clk_i);
    start_i = 1'b1; len_i = LEN_W'(len); scale_i = SCALE_W'(sc); in_valid_i = 1'b0;
    @(posedge clk_i);
    for (int b = 0; b < len; b++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        @(negedge clk_i);
        start_i = 1'b0; in_valid_i = 1'b0;
        act_i = {$urandom, $urandom}; wgt_i = LANES'($urandom);
        @(posedge clk_i);
      end
      @(negedge clk_i);
      start_i = 1'b0; in_valid_i = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        int a; bit w;
        case (mode)
          3: begin a = -(1 << (ACT_W-1)); w = 1'b1; end
          4: begin a = (l == 0) ? fixv : 0; w = 1'b1; end
          default: begin
            a = int'($urandom_range(0, (1 << ACT_W) - 1)) - (1 << (ACT_W-1));
            w = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom);
          end
        endcase
        act_i[l*ACT_W +: ACT_W] = ACT_W'(a);
        wgt_i[l] = w;
        acc += w ? a : -a;
      end
      @(posedge clk_i);
    end
    @(negedge clk_i);
    start_i = 1'b0; in_valid_i = junk;
    act_i = {$urandom, $urandom}; wgt_i = LANES'($urandom);
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk_i); #1;
      chk(out_valid_o == (k == 3), {"R8 strobe timing ", tag}, out_valid_o, k == 3);
    end
    chk($signed(result_o) == exp_res(acc, longint'($signed(SCALE_W'(sc)))), tag,
        $signed(result_o), exp_res(acc, longint'($signed(SCALE_W'(sc)))));
    chk(!busy_o, "R8 busy low at strobe", busy_o, 0);
    @(posedge clk_i); #1;
    chk(!out_valid_o, "R8 single-cycle strobe", out_valid_o, 0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    logic [OUT_W-1:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1;
    chk(!out_valid_o && !busy_o && result_o == '0, "R11 reset state", result_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int j = 0; j < 20; j++)
      run_job($urandom_range(1, 40), int'($urandom_range(0, 1023)) - 512, 0, 0, 1'b1, 1'b0,
              "R1 R2 R5 random");
    run_job(37, 256, 1, 0, 1'b1, 1'b0, "R1 all weights one");
    run_job(29, 256, 2, 0, 1'b0, 1'b0, "R1 all weights zero");
    run_job(16, 300, 0, 0, 1'b1, 1'b1, "R3 extra beats ignored");
    run_job(1, 128, 4, 3, 1'b0, 1'b0, "R6 half rounds up +1.5");
    run_job(1, 128, 4, -3, 1'b0, 1'b0, "R6 half rounds up -1.5");
    run_job(1, 64, 4, 5, 1'b0, 1'b0, "R6 1.25 rounds down");
    run_job(200, 32767, 3, 0, 1'b0, 1'b0, "R7 negative clamp");
    run_job(200, -32768, 3, 0, 1'b0, 1'b0, "R7 positive clamp");
    run_job(0, 500, 0, 0, 1'b0, 1'b0, "R9 zero length");

    // R4: abort a running job, the restart alone counts
    @(negedge clk_i);
    start_i = 1'b1; len_i = 16'd10; scale_i = 16'd256;
    @(negedge clk_i);
    start_i = 1'b0; in_valid_i = 1'b1; act_i = {4{8'sd100}}; wgt_i = '1;
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o && busy_o, "R4 running before abort", out_valid_o, 0);
    run_job(5, 256, 0, 0, 1'b0, 1'b0, "R4 restart result");

    // R11 / R3: idle beats do not move the held result
    held = result_o;
    @(negedge clk_i);
    in_valid_i = 1'b1; act_i = {$urandom, $urandom}; wgt_i = '1;
    repeat (6) @(negedge clk_i);
    chk(result_o == held && !out_valid_o, "R11 R3 result held while idle", result_o, held);
    in_valid_i = 1'b0;

    run_job(65535, 1, 3, 0, 1'b0, 1'b0, "R10 longest job no wrap");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule